// File: doc/BRIEF.md
# Streaming-Read SPI Slave Controller

This block is the SPI slave front end of a small register file. It uses SPI mode 3: SCLK idles high, the slave changes SDO on falling edges, and the master samples on rising edges. All SPI pins are synchronised into the system clock domain. Three fixed instruction bytes control a streaming mode. When streaming is on, every chip-select assertion that begins with SCLK high sends out a burst of registers at once, with no instruction byte. The burst starts at a programmable start address and has a programmable length.

The start address and the burst length sit in their own window registers, which are loaded through a parallel configuration port. The paged upper-address register that normal reads use is a separate register, and a burst never changes it. After a burst has finished, the rest of the same frame is decoded as an ordinary instruction. That instruction can be the one that turns streaming off.

Normal access is kept to a minimum. One instruction loads the upper-address page, and read instructions stream registers from the current page. Register writes and conversion logic belong to other blocks.

Top module: `spi_stream_slave`

## Requirements
- R1: After reset, streaming mode is off, sdo_oe is low, the start address is 0, the burst count field is 0 and the upper-address page is 0.
- R2: Instruction byte 8'hFA turns streaming mode on and 8'hFB turns it off. No data byte follows either one, so sdo_oe stays low for any further bytes in that frame.
- R3: Instruction byte 8'h9F is followed by one status byte that the slave drives, MSB first. Bit 1 of that byte is 1 when streaming mode is on, and all other bits are 0.
- R4: With streaming on, a CSB falling edge with SCLK high starts a burst at once. The burst has count+1 bytes, where count is the 3-bit count field, so it covers 1 to 8 bytes, and no instruction byte is expected.
- R5: Burst byte k comes from register address (start + k) mod 128. The address increments once per byte and wraps from 7'h7F to 7'h00.
- R6: SDO carries each byte MSB first. A bit is placed on SDO after a SCLK falling edge and is valid at the next rising edge. The first bit of a burst appears after the first falling edge of the frame.
- R7: After the last burst byte, the next 8 bits in the same frame are decoded as a normal instruction. This includes 8'hFB and 8'h9F.
- R8: A burst takes its full 7-bit address only from the start-address register. The upper-address page keeps its value across any number of bursts.
- R9: Instruction 8'h10 followed by one byte loads the upper-address page from bits [2:0] of that byte. Any other instruction with bit 7 set, apart from 8'hFA, 8'hFB and 8'h9F, is a read. The read streams registers starting at {page, instruction[3:0]} and increments by one address per byte.
- R10: sdo_oe is low while CSB is high and while the slave is receiving instruction or argument bits. It is high only while a burst, a status or a read byte is being shifted out.
- R11: With streaming on, a frame whose CSB falling edge finds SCLK low starts no burst. Its first byte is decoded as a normal instruction.
- R12: A configuration write with cfg_sel=0 loads the start address from cfg_wdata[6:0]. With cfg_sel=1 it loads the count field from cfg_wdata[2:0]. The new value takes effect one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csb | input | 1 | SPI chip select, active low |
| sclk | input | 1 | SPI serial clock, idle high |
| sdi | input | 1 | Serial data from the master |
| sdo | output | 1 | Serial data to the master |
| sdo_oe | output | 1 | Output enable for the SDO pad driver |
| rd_addr | output | 7 | Register file read address |
| rd_data | input | 8 | Register file read data (combinational) |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 selects start address, 1 selects count |
| cfg_wdata | input | 7 | Configuration write data |

## Verification
Each SCLK edge reaches the logic through two synchroniser stages and one edge register. A new SDO bit therefore appears about four system clocks after the falling edge. The bench holds each SCLK phase for eight clocks and samples SDO and sdo_oe on the clock before it raises SCLK, so every sample falls inside the window where the bit is settled. Instructions take effect about five clocks after the eighth rising edge, which is before the next falling edge. Configuration writes take effect one clock after the strobe, and the bench always writes them well before the next frame.

// File: rtl/spi_df_pkg.sv
package spi_df_pkg;

   localparam int BYTE_W = 8;

   localparam logic [BYTE_W-1:0] OP_STREAM_ON  = 8'hFA;
   localparam logic [BYTE_W-1:0] OP_STREAM_OFF = 8'hFB;
   localparam logic [BYTE_W-1:0] OP_MODE_STAT  = 8'h9F;
   localparam logic [BYTE_W-1:0] OP_SET_PAGE   = 8'h10;

   localparam int STAT_BIT = 1;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_BURST,
      ST_INSTR,
      ST_STAT,
      ST_RD,
      ST_PAGE,
      ST_SKIP
   } df_state_t;

endpackage

// File: rtl/spi_df_sync.sv
module spi_df_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic csb,
   input  logic sclk,
   input  logic sdi,
   output logic cs_act,
   output logic cs_fall,
   output logic sclk_hi,
   output logic sclk_rise,
   output logic sclk_fall,
   output logic sdi_s
);

   if (STAGES < 2) begin : g_bad_stages
      $error("spi_df_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] csb_q, sclk_q, sdi_q;
   logic              csb_d, sclk_d;

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               csb_q[0]  <= 1'b1;
               sclk_q[0] <= 1'b1;
               sdi_q[0]  <= 1'b0;
            end else begin
               csb_q[0]  <= csb;
               sclk_q[0] <= sclk;
               sdi_q[0]  <= sdi;
            end
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               csb_q[g]  <= 1'b1;
               sclk_q[g] <= 1'b1;
               sdi_q[g]  <= 1'b0;
            end else begin
               csb_q[g]  <= csb_q[g-1];
               sclk_q[g] <= sclk_q[g-1];
               sdi_q[g]  <= sdi_q[g-1];
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         csb_d  <= 1'b1;
         sclk_d <= 1'b1;
      end else begin
         csb_d  <= csb_q[STAGES-1];
         sclk_d <= sclk_q[STAGES-1];
      end
   end

   assign cs_act    = ~csb_q[STAGES-1];
   assign cs_fall   = csb_d & ~csb_q[STAGES-1];
   assign sclk_hi   = sclk_q[STAGES-1];
   assign sclk_rise = cs_act & ~sclk_d & sclk_q[STAGES-1];
   assign sclk_fall = cs_act & sclk_d & ~sclk_q[STAGES-1];
   assign sdi_s     = sdi_q[STAGES-1];

endmodule

// File: rtl/spi_df_shifter.sv
module spi_df_shifter
   import spi_df_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_act,
   input  logic              sclk_rise,
   input  logic              sclk_fall,
   input  logic              sdi_s,
   input  logic [BYTE_W-1:0] tx_byte,
   input  logic              tx_en,
   output logic [BYTE_W-1:0] rx_byte,
   output logic              byte_done,
   output logic              sdo,
   output logic              sdo_oe
);

   localparam int CNT_W = $clog2(BYTE_W);
   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

   if ((1 << CNT_W) != BYTE_W) begin : g_bad_width
      $error("spi_df_shifter: byte width must be a power of two");
   end

   logic [CNT_W-1:0]  bit_cnt;
   logic [BYTE_W-2:0] rx_sh;
   logic [BYTE_W-1:0] tx_sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_cnt   <= '0;
         rx_sh     <= '0;
         rx_byte   <= '0;
         byte_done <= 1'b0;
         tx_sh     <= '0;
         sdo       <= 1'b0;
         sdo_oe    <= 1'b0;
      end else if (!cs_act) begin
         bit_cnt   <= '0;
         byte_done <= 1'b0;
         sdo_oe    <= 1'b0;
      end else begin
         byte_done <= 1'b0;
         if (sclk_rise) begin
            rx_sh <= {rx_sh[BYTE_W-3:0], sdi_s};
            if (bit_cnt == LAST_BIT) begin
               bit_cnt   <= '0;
               byte_done <= 1'b1;
               rx_byte   <= {rx_sh, sdi_s};
            end else begin
               bit_cnt <= bit_cnt + 1'b1;
            end
         end
         if (sclk_fall) begin
            if (bit_cnt == '0) begin
               sdo    <= tx_byte[BYTE_W-1];
               tx_sh  <= {tx_byte[BYTE_W-2:0], 1'b0};
               sdo_oe <= tx_en;
            end else begin
               sdo   <= tx_sh[BYTE_W-1];
               tx_sh <= {tx_sh[BYTE_W-2:0], 1'b0};
            end
         end
      end
   end

   p_oe_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_act |=> !sdo_oe);

   p_oe_on_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sdo_oe) |-> $past(sclk_fall));

   p_done_on_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
      byte_done |-> $past(sclk_rise));

endmodule

// File: rtl/spi_df_window.sv
module spi_df_window #(
   parameter int ADDR_W = 7,
   parameter int CNT_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic              cfg_sel,
   input  logic [ADDR_W-1:0] cfg_wdata,
   output logic [ADDR_W-1:0] start_addr,
   output logic [CNT_W-1:0]  burst_cnt
);

   if (CNT_W > ADDR_W) begin : g_bad_cnt
      $error("spi_df_window: CNT_W must not exceed ADDR_W");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         start_addr <= '0;
         burst_cnt  <= '0;
      end else if (cfg_we) begin
         if (cfg_sel) burst_cnt  <= cfg_wdata[CNT_W-1:0];
         else         start_addr <= cfg_wdata;
      end
   end

   p_cfg_start_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && !cfg_sel) |=> start_addr == $past(cfg_wdata));

   p_cfg_cnt_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_sel) |=> burst_cnt == $past(cfg_wdata[CNT_W-1:0]));

endmodule

// File: rtl/spi_df_ctrl.sv
module spi_df_ctrl
   import spi_df_pkg::*;
#(
   parameter int ADDR_W = 7,
   parameter int LOW_W  = 4,
   parameter int CNT_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_act,
   input  logic              cs_fall,
   input  logic              sclk_hi,
   input  logic              byte_done,
   input  logic [BYTE_W-1:0] rx_byte,
   input  logic [ADDR_W-1:0] start_addr,
   input  logic [CNT_W-1:0]  burst_cnt,
   input  logic [BYTE_W-1:0] rd_data,
   output logic [ADDR_W-1:0] rd_addr,
   output logic [BYTE_W-1:0] tx_byte,
   output logic              tx_en
);

   localparam int PAGE_W = ADDR_W - LOW_W;

   if (LOW_W < 1 || PAGE_W < 1 || PAGE_W > BYTE_W || LOW_W > 4) begin : g_bad_split
      $error("spi_df_ctrl: address split out of range");
   end

   df_state_t         state;
   logic [ADDR_W-1:0] addr;
   logic [CNT_W-1:0]  left;
   logic [PAGE_W-1:0] page;
   logic              stream_on;
   logic [BYTE_W-1:0] status_byte;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         addr      <= '0;
         left      <= '0;
         page      <= '0;
         stream_on <= 1'b0;
      end else if (!cs_act) begin
         state <= ST_IDLE;
      end else if (cs_fall) begin
         if (stream_on && sclk_hi) begin
            state <= ST_BURST;
            addr  <= start_addr;
            left  <= burst_cnt;
         end else begin
            state <= ST_INSTR;
         end
      end else if (byte_done) begin
         unique case (state)
            ST_BURST: begin
               if (left == '0) begin
                  state <= ST_INSTR;
               end else begin
                  left <= left - 1'b1;
                  addr <= addr + 1'b1;
               end
            end
            ST_INSTR: begin
               if (rx_byte == OP_STREAM_ON) begin
                  stream_on <= 1'b1;
                  state     <= ST_SKIP;
               end else if (rx_byte == OP_STREAM_OFF) begin
                  stream_on <= 1'b0;
                  state     <= ST_SKIP;
               end else if (rx_byte == OP_MODE_STAT) begin
                  state <= ST_STAT;
               end else if (rx_byte == OP_SET_PAGE) begin
                  state <= ST_PAGE;
               end else if (rx_byte[BYTE_W-1]) begin
                  state <= ST_RD;
                  addr  <= {page, rx_byte[LOW_W-1:0]};
               end else begin
                  state <= ST_SKIP;
               end
            end
            ST_STAT: state <= ST_SKIP;
            ST_RD:   addr  <= addr + 1'b1;
            ST_PAGE: begin
               page  <= rx_byte[PAGE_W-1:0];
               state <= ST_SKIP;
            end
            default: state <= state;
         endcase
      end
   end

   always_comb begin
      status_byte           = '0;
      status_byte[STAT_BIT] = stream_on;
   end

   assign rd_addr = addr;
   assign tx_byte = (state == ST_STAT) ? status_byte : rd_data;
   assign tx_en   = (state == ST_BURST) || (state == ST_STAT) || (state == ST_RD);

   p_burst_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_act && cs_fall && stream_on && sclk_hi) |=>
         (state == ST_BURST && addr == $past(start_addr) && left == $past(burst_cnt)));

   p_low_sclk_no_burst_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_act && cs_fall && !sclk_hi) |=> state == ST_INSTR);

   p_page_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_BURST) |=> $stable(page));

   p_addr_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_act && !cs_fall && state == ST_BURST && byte_done && left != '0 && addr == '1)
         |=> addr == '0);

   p_mode_on_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stream_on) |-> $past(state == ST_INSTR && byte_done && rx_byte == OP_STREAM_ON));

   p_burst_after_instr_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_act && !cs_fall && state == ST_BURST && byte_done && left == '0)
         |=> state == ST_INSTR);

endmodule

// File: rtl/spi_stream_slave.sv
module spi_stream_slave
   import spi_df_pkg::*;
#(
   parameter int ADDR_W      = 7,
   parameter int LOW_W       = 4,
   parameter int CNT_W       = 3,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              csb,
   input  logic              sclk,
   input  logic              sdi,
   output logic              sdo,
   output logic              sdo_oe,
   output logic [ADDR_W-1:0] rd_addr,
   input  logic [BYTE_W-1:0] rd_data,
   input  logic              cfg_we,
   input  logic              cfg_sel,
   input  logic [ADDR_W-1:0] cfg_wdata
);

   if (ADDR_W > BYTE_W || ADDR_W < 2) begin : g_bad_addr
      $error("spi_stream_slave: ADDR_W out of range");
   end
   if (LOW_W >= ADDR_W) begin : g_bad_low
      $error("spi_stream_slave: LOW_W must be below ADDR_W");
   end

   logic              cs_act, cs_fall, sclk_hi, sclk_rise, sclk_fall, sdi_s;
   logic              byte_done, tx_en;
   logic [BYTE_W-1:0] rx_byte, tx_byte;
   logic [ADDR_W-1:0] start_addr;
   logic [CNT_W-1:0]  burst_cnt;

   spi_df_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .csb       (csb),
      .sclk      (sclk),
      .sdi       (sdi),
      .cs_act    (cs_act),
      .cs_fall   (cs_fall),
      .sclk_hi   (sclk_hi),
      .sclk_rise (sclk_rise),
      .sclk_fall (sclk_fall),
      .sdi_s     (sdi_s)
   );

   spi_df_shifter u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .cs_act    (cs_act),
      .sclk_rise (sclk_rise),
      .sclk_fall (sclk_fall),
      .sdi_s     (sdi_s),
      .tx_byte   (tx_byte),
      .tx_en     (tx_en),
      .rx_byte   (rx_byte),
      .byte_done (byte_done),
      .sdo       (sdo),
      .sdo_oe    (sdo_oe)
   );

   spi_df_window #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_window (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg_we     (cfg_we),
      .cfg_sel    (cfg_sel),
      .cfg_wdata  (cfg_wdata),
      .start_addr (start_addr),
      .burst_cnt  (burst_cnt)
   );

   spi_df_ctrl #(.ADDR_W(ADDR_W), .LOW_W(LOW_W), .CNT_W(CNT_W)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .cs_act     (cs_act),
      .cs_fall    (cs_fall),
      .sclk_hi    (sclk_hi),
      .byte_done  (byte_done),
      .rx_byte    (rx_byte),
      .start_addr (start_addr),
      .burst_cnt  (burst_cnt),
      .rd_data    (rd_data),
      .rd_addr    (rd_addr),
      .tx_byte    (tx_byte),
      .tx_en      (tx_en)
   );

endmodule

// File: tb/spi_stream_slave_bench.sv
module spi_stream_slave_bench;

   localparam int HP = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       csb = 1'b1, sclk = 1'b1, sdi = 1'b0;
   logic       sdo, sdo_oe;
   logic [6:0] rd_addr;
   logic [7:0] rd_data;
   logic       cfg_we = 1'b0, cfg_sel = 1'b0;
   logic [6:0] cfg_wdata = '0;

   always #4 clk = ~clk;

   logic [7:0] mem [128];
   assign rd_data = mem[rd_addr];

   spi_stream_slave u_spi_stream_slave (
      .clk(clk), .rst_n(rst_n), .csb(csb), .sclk(sclk), .sdi(sdi),
      .sdo(sdo), .sdo_oe(sdo_oe), .rd_addr(rd_addr), .rd_data(rd_data),
      .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata)
   );

   int n_chk = 0, n_bad = 0;

   bit         m_on = 1'b0;
   logic [6:0] m_start = '0;
   logic [2:0] m_cnt = '0;
   logic [2:0] m_page = '0;

   logic [7:0] tx_q [16];
   logic [7:0] rx_q [16];
   bit         oe_all [16];
   bit         oe_any [16];

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic finish_up();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   endtask

   function automatic logic [7:0] exp_burst(input int k);
      return mem[7'(m_start + 7'(k))];
   endfunction

   function automatic logic [7:0] exp_read(input logic [3:0] lo, input int k);
      return mem[7'({m_page, lo} + 7'(k))];
   endfunction

   function automatic logic [7:0] exp_status();
      return {6'b0, m_on, 1'b0};
   endfunction

   function automatic int burst_len(input bit hi);
      return (m_on && hi) ? int'(m_cnt) + 1 : 0;
   endfunction

   task automatic cfg_write(input bit sel, input logic [6:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
      if (sel) m_cnt = d[2:0];
      else     m_start = d;
   endtask

   task automatic spi_frame(input int total, input bit hi);
      @(negedge clk);
      sclk = hi;
      repeat (HP) @(negedge clk);
      csb = 1'b0;
      repeat (HP) @(negedge clk);
      for (int i = 0; i < total; i++) begin
         oe_all[i] = 1'b1; oe_any[i] = 1'b0; rx_q[i] = '0;
         for (int b = 7; b >= 0; b--) begin
            sclk = 1'b0; sdi = tx_q[i][b];
            repeat (HP) @(negedge clk);
            rx_q[i][b] = sdo;
            oe_all[i] = oe_all[i] & sdo_oe;
            oe_any[i] = oe_any[i] | sdo_oe;
            sclk = 1'b1;
            repeat (HP) @(negedge clk);
         end
      end
      csb = 1'b1; sclk = 1'b1;
      repeat (2 * HP) @(negedge clk);
      chk("R10 oe after CSB high", int'(sdo_oe), 0);
   endtask

   task automatic check_burst(input int nb);
      for (int k = 0; k < nb; k++) begin
         chk("R4 R5 burst byte", int'(rx_q[k]), int'(exp_burst(k)));
         chk("R6 burst byte driven", int'(oe_all[k]), 1);
      end
   endtask

   // frame = optional burst followed by one command byte and nd trailing bytes
   task automatic cmd_frame(input logic [7:0] op, input logic [7:0] arg,
                            input int nd, input bit hi, output int nb);
      nb = burst_len(hi);
      for (int k = 0; k < nb; k++) tx_q[k] = 8'h00;
      tx_q[nb] = op;
      for (int k = 0; k < nd; k++) tx_q[nb + 1 + k] = arg;
      spi_frame(nb + 1 + nd, hi);
      check_burst(nb);
      chk("R10 instruction byte not driven", int'(oe_any[nb]), 0);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
      finish_up();
   end

   initial begin
      int nb;
      void'($urandom(32'd20240611));
      for (int i = 0; i < 128; i++) mem[i] = 8'($urandom);

      repeat (5) @(negedge clk);
      chk("R1 R10 oe in reset", int'(sdo_oe), 0);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      chk("R1 rd_addr after reset", int'(rd_addr), 0);

      // status with streaming off
      cmd_frame(8'h9F, 8'h00, 1, 1'b1, nb);
      chk("R1 R3 status after reset", int'(rx_q[nb + 1]), 0);
      chk("R3 status driven", int'(oe_all[nb + 1]), 1);

      // window config; high cfg bits must be dropped for count
      cfg_write(1'b0, 7'h20);
      cfg_write(1'b1, 7'h7B);
      chk("R12 count field", int'(m_cnt), 3);

      cmd_frame(8'hFA, 8'h00, 1, 1'b1, nb);
      chk("R2 no data after enable", int'(oe_any[nb + 1]), 0);
      m_on = 1'b1;

      // burst then status in same frame
      cmd_frame(8'h9F, 8'h00, 1, 1'b1, nb);
      chk("R4 burst length", nb, 4);
      chk("R3 R7 status after burst", int'(rx_q[nb + 1]), int'(exp_status()));

      // load page 5, then read from page
      cmd_frame(8'h10, 8'h05, 1, 1'b1, nb);
      chk("R9 page argument not driven", int'(oe_any[nb + 1]), 0);
      m_page = 3'd5;
      cmd_frame(8'h83, 8'h00, 2, 1'b1, nb);
      chk("R9 read byte 0", int'(rx_q[nb + 1]), int'(exp_read(4'h3, 0)));
      chk("R9 read byte 1", int'(rx_q[nb + 2]), int'(exp_read(4'h3, 1)));

      // several bursts, page must survive
      for (int r = 0; r < 3; r++) begin
         cmd_frame(8'h00, 8'h00, 0, 1'b1, nb);
      end
      cmd_frame(8'h8E, 8'h00, 2, 1'b1, nb);
      chk("R8 page kept after bursts", int'(rx_q[nb + 1]), int'(exp_read(4'hE, 0)));
      chk("R8 R9 read increments", int'(rx_q[nb + 2]), int'(exp_read(4'hE, 1)));

      // maximum length burst that wraps the address space
      cfg_write(1'b0, 7'h7E);
      cfg_write(1'b1, 7'h07);
      cmd_frame(8'h00, 8'h00, 0, 1'b1, nb);
      chk("R4 max burst length", nb, 8);
      chk("R5 wrap byte", int'(rx_q[2]), int'(mem[0]));

      // SCLK low at CSB fall: no burst
      cmd_frame(8'h9F, 8'h00, 1, 1'b0, nb);
      chk("R11 no burst with SCLK low", nb, 0);
      chk("R11 status decoded first", int'(rx_q[1]), int'(exp_status()));

      // disable after burst in same frame
      cmd_frame(8'hFB, 8'h55, 1, 1'b1, nb);
      chk("R2 R7 no data after disable", int'(oe_any[nb + 1]), 0);
      m_on = 1'b0;
      cmd_frame(8'h9F, 8'h00, 1, 1'b1, nb);
      chk("R2 streaming off", nb, 0);
      chk("R2 R3 status off", int'(rx_q[1]), 0);

      // re-enable and run randomized windows
      cmd_frame(8'hFA, 8'h00, 0, 1'b1, nb);
      m_on = 1'b1;
      for (int it = 0; it < 24; it++) begin
         logic [3:0] lo;
         cfg_write(1'b0, 7'($urandom));
         cfg_write(1'b1, 7'($urandom));
         if (it % 4 == 0) begin
            logic [7:0] pg;
            pg = 8'($urandom);
            cmd_frame(8'h10, pg, 1, 1'b1, nb);
            m_page = pg[2:0];
         end
         lo = 4'($urandom);
         cmd_frame({4'h8, lo}, 8'h00, 2, 1'b1, nb);
         chk("R9 random read 0", int'(rx_q[nb + 1]), int'(exp_read(lo, 0)));
         chk("R9 random read 1", int'(rx_q[nb + 2]), int'(exp_read(lo, 1)));
         chk("R8 R10 read driven", int'(oe_all[nb + 1]), 1);
      end

      finish_up();
   end

endmodule